// File: doc/BRIEF.md
# Tagged-Entry FIFO Packer and Unpacker

This block sits between a 32-bit register port and a serial bus engine that works on 16-bit entries, each entry being a tag plus one data byte. On the transmit side, software writes 32-bit words that carry two entries at once, or one entry alone for the odd last entry of a message. The block queues them in order, and the engine takes them one per handshake. On the receive side, the engine hands over one byte per handshake. The block stores each byte as an entry, and software collects two bytes per 32-bit read.

Software programs how many entries each direction's transfer holds. A sticky done bit rises when that many entries have been moved. In block mode, a service bit also rises after every completed block of entries, so software can refill or drain the queues in chunks instead of waiting for the whole transfer. Service bits and the overflow bit are cleared by writing 1 to them. The block also reports out-not-empty, in-not-empty and out-full levels.

Top module: `tef_packer`

## Requirements
- R1: A write to address 4 queues reg_wdata[15:0] first and reg_wdata[31:16] second. The engine receives entries in queue order, and an offered entry is held stable until it is taken.
- R2: A write to address 5 queues only reg_wdata[15:0]. The upper half is discarded.
- R3: A push write that does not fit in the free space of the transmit queue is dropped whole and sets the overflow bit (status bit 2). The queued entries are left unchanged.
- R4: A read of address 6 returns the oldest received byte in bits [7:0] and the next one in bits [23:16], with all other bits zero, and removes both bytes. With one byte held, the read returns and removes only that byte. With none held, the read returns zero.
- R5: Status (address 0) reports transmit-not-empty at bit 4, receive-not-empty at bit 5 and transmit-full at bit 6. eng_in_ready is low exactly while the receive queue is full.
- R6: Writing address 2 (transmit) or address 3 (receive) sets the entry count and clears that direction's progress and done bit. Done (bit 10 for transmit, bit 11 for receive) rises when the moved entries reach a nonzero count, and it stays set.
- R7: When mode bit 0 (transmit) or mode bit 1 (receive) of address 1 is set, the service bit (bit 8 for transmit, bit 9 for receive) rises each time BLOCK more entries have moved. With the mode bit clear, the service bit is never raised.
- R8: Writing address 0 clears each of bits 2, 8 and 9 that is written as 1. Bits written as 0 keep their value. A new event in the same cycle wins over the clear.
- R9: After reset, status reads zero, eng_out_valid is low and eng_in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 6) |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| eng_out_valid | output | 1 | Transmit entry available |
| eng_out_ready | input | 1 | Engine takes the transmit entry |
| eng_out_entry | output | 16 | Head transmit entry |
| eng_in_valid | input | 1 | Engine offers a received byte |
| eng_in_ready | output | 1 | Receive queue has room |
| eng_in_byte | input | 8 | Received byte |

## Verification
A register write or engine handshake takes effect at the clock edge that follows the strobe. Status, done and service bits are therefore due one edge later, and the bench reads them only at the next falling edge or later. The pop read data is combinational, so it is sampled one nanosecond after the read strobe is raised, before the popping edge. The transmit monitor compares each entry at the falling edge before the edge that takes it, so the comparison follows the handshake cycle by cycle, including the entries dropped on overflow.

// File: rtl/tef_pkg.sv
// Shared constants for the tagged-entry packer: register selects and status bit positions.
package tef_pkg;
    localparam int WORD_W  = 32;
    localparam int ENTRY_W = 16;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS    = 3'd0,
        REG_MODE      = 3'd1,
        REG_OUT_CNT   = 3'd2,
        REG_IN_CNT    = 3'd3,
        REG_PUSH_PAIR = 3'd4,
        REG_PUSH_ONE  = 3'd5,
        REG_POP       = 3'd6,
        REG_SPARE     = 3'd7
    } reg_sel_e;

    localparam int ST_OVF      = 2;
    localparam int ST_OUT_NE   = 4;
    localparam int ST_IN_NE    = 5;
    localparam int ST_OUT_FULL = 6;
    localparam int ST_OUT_SVC  = 8;
    localparam int ST_IN_SVC   = 9;
    localparam int ST_OUT_DONE = 10;
    localparam int ST_IN_DONE  = 11;
endpackage

// File: rtl/tef_fifo.sv
// Circular queue that accepts up to two items and releases up to two items per cycle.
// Assumes: DEPTH is a power of two, at least 4. The caller never pushes beyond the free
// space and never pops beyond the level. push_data low half goes in first.
module tef_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     push_n,
    input  logic [2*W-1:0] push_data,
    input  logic [1:0]     pop_n,
    output logic [W-1:0]   head0,
    output logic [W-1:0]   head1,
    output logic [LW-1:0]  level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW-1:0] wr_ptr_nx, rd_ptr_nx;

    assign wr_ptr_nx = wr_ptr + AW'(1);
    assign rd_ptr_nx = rd_ptr + AW'(1);

    // Storage write: first item at wr_ptr, second at the slot after it.
    always_ff @(posedge clk) begin
        if (push_n != 2'd0) mem[wr_ptr] <= push_data[W-1:0];
        if (push_n == 2'd2) mem[wr_ptr_nx] <= push_data[2*W-1:W];
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push_n);
            rd_ptr <= rd_ptr + AW'(pop_n);
            level  <= level + LW'(push_n) - LW'(pop_n);
        end
    end

    assign head0 = mem[rd_ptr];
    assign head1 = mem[rd_ptr_nx];
endmodule

// File: rtl/tef_progress.sv
// Per-direction transfer tracker: counts moved entries against a programmed total,
// raises a sticky done bit and emits a service pulse at each block boundary in block mode.
// Assumes: at most one entry moves per cycle, and BLOCK is a power of two, at least 2.
module tef_progress #(
    parameter int CNT_W = 16,
    parameter int BLOCK = 8,
    localparam int BW   = $clog2(BLOCK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    input  logic             blk_mode,
    output logic             done,
    output logic             svc_pulse
);
    logic [CNT_W-1:0] target, moved;
    logic [BW-1:0]    blk_pos;
    logic             blk_end;

    assign blk_end   = (blk_pos == BW'(BLOCK - 1));
    assign svc_pulse = step && !load && blk_mode && blk_end;

    // Progress and done: a load restarts the transfer, a step advances it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target  <= '0;
            moved   <= '0;
            blk_pos <= '0;
            done    <= 1'b0;
        end else if (load) begin
            target  <= load_val;
            moved   <= '0;
            blk_pos <= '0;
            done    <= 1'b0;
        end else if (step) begin
            moved   <= moved + CNT_W'(1);
            blk_pos <= blk_end ? '0 : blk_pos + BW'(1);
            if (target != '0 && (moved + CNT_W'(1)) == target) done <= 1'b1;
        end
    end
endmodule

// File: rtl/tef_packer.sv
// Top of the tagged-entry packer: register decode, transmit and receive queues,
// progress trackers and write-1-to-clear flags.
// Assumes: one register access per cycle, and the engine observes valid/ready handshakes.
module tef_packer
    import tef_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BLOCK = 8,
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic                eng_out_valid,
    input  logic                eng_out_ready,
    output logic [ENTRY_W-1:0]  eng_out_entry,
    input  logic                eng_in_valid,
    output logic                eng_in_ready,
    input  logic [BYTE_W-1:0]   eng_in_byte
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    reg_sel_e sel;
    logic wr_status, wr_mode, wr_out_cnt, wr_in_cnt, wr_pair, wr_one, rd_pop;
    logic [LW-1:0] out_level, in_level;
    logic [1:0] opush_n, opop_n, ipush_n, ipop_n;
    logic [ENTRY_W-1:0] ohead1_unused;
    logic [BYTE_W-1:0] ihead0, ihead1;
    logic fits_pair, fits_one, drop;
    logic out_take, in_take;
    logic out_done, in_done, out_svc_pulse, in_svc_pulse;
    logic ovf_q, out_svc_q, in_svc_q, mode_out_blk_q, mode_in_blk_q;
    logic [WORD_W-1:0] status;

    // Decode the register strobe into per-register events.
    assign sel        = reg_sel_e'(reg_addr);
    assign wr_status  = reg_wr && sel == REG_STATUS;
    assign wr_mode    = reg_wr && sel == REG_MODE;
    assign wr_out_cnt = reg_wr && sel == REG_OUT_CNT;
    assign wr_in_cnt  = reg_wr && sel == REG_IN_CNT;
    assign wr_pair    = reg_wr && sel == REG_PUSH_PAIR;
    assign wr_one     = reg_wr && sel == REG_PUSH_ONE;
    assign rd_pop     = reg_rd && sel == REG_POP;

    // Transmit admission: a push is accepted whole or dropped whole.
    assign fits_pair = out_level <= LW'(DEPTH - 2);
    assign fits_one  = out_level != LW'(DEPTH);
    assign drop      = (wr_pair && !fits_pair) || (wr_one && !fits_one);

    always_comb begin
        opush_n = 2'd0;
        if (wr_pair && fits_pair)     opush_n = 2'd2;
        else if (wr_one && fits_one)  opush_n = 2'd1;
    end

    assign eng_out_valid = out_level != '0;
    assign out_take      = eng_out_valid && eng_out_ready;
    assign opop_n        = {1'b0, out_take};

    tef_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_out_q (
        .clk(clk), .rst_n(rst_n),
        .push_n(opush_n), .push_data(reg_wdata),
        .pop_n(opop_n),
        .head0(eng_out_entry), .head1(ohead1_unused),
        .level(out_level)
    );

    // Receive side: one byte per handshake, up to two bytes per pop read.
    assign eng_in_ready = in_level != LW'(DEPTH);
    assign in_take      = eng_in_valid && eng_in_ready;
    assign ipush_n      = {1'b0, in_take};

    always_comb begin
        ipop_n = 2'd0;
        if (rd_pop) begin
            if (in_level >= LW'(2))      ipop_n = 2'd2;
            else if (in_level != '0)     ipop_n = 2'd1;
        end
    end

    tef_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_in_q (
        .clk(clk), .rst_n(rst_n),
        .push_n(ipush_n), .push_data({{BYTE_W{1'b0}}, eng_in_byte}),
        .pop_n(ipop_n),
        .head0(ihead0), .head1(ihead1),
        .level(in_level)
    );

    // Progress trackers, one per direction.
    tef_progress #(.CNT_W(CNT_W), .BLOCK(BLOCK)) u_out_prog (
        .clk(clk), .rst_n(rst_n),
        .load(wr_out_cnt), .load_val(reg_wdata[CNT_W-1:0]),
        .step(out_take), .blk_mode(mode_out_blk_q),
        .done(out_done), .svc_pulse(out_svc_pulse)
    );

    tef_progress #(.CNT_W(CNT_W), .BLOCK(BLOCK)) u_in_prog (
        .clk(clk), .rst_n(rst_n),
        .load(wr_in_cnt), .load_val(reg_wdata[CNT_W-1:0]),
        .step(in_take), .blk_mode(mode_in_blk_q),
        .done(in_done), .svc_pulse(in_svc_pulse)
    );

    // Mode register: block-mode enables for each direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_out_blk_q <= 1'b0;
            mode_in_blk_q  <= 1'b0;
        end else if (wr_mode) begin
            mode_out_blk_q <= reg_wdata[0];
            mode_in_blk_q  <= reg_wdata[1];
        end
    end

    // Sticky event flags, cleared by writing 1; a fresh event beats the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q     <= 1'b0;
            out_svc_q <= 1'b0;
            in_svc_q  <= 1'b0;
        end else begin
            ovf_q     <= drop          | (ovf_q     & ~(wr_status & reg_wdata[ST_OVF]));
            out_svc_q <= out_svc_pulse | (out_svc_q & ~(wr_status & reg_wdata[ST_OUT_SVC]));
            in_svc_q  <= in_svc_pulse  | (in_svc_q  & ~(wr_status & reg_wdata[ST_IN_SVC]));
        end
    end

    // Assemble the status word.
    always_comb begin
        status              = '0;
        status[ST_OVF]      = ovf_q;
        status[ST_OUT_NE]   = eng_out_valid;
        status[ST_IN_NE]    = in_level != '0;
        status[ST_OUT_FULL] = !fits_one;
        status[ST_OUT_SVC]  = out_svc_q;
        status[ST_IN_SVC]   = in_svc_q;
        status[ST_OUT_DONE] = out_done;
        status[ST_IN_DONE]  = in_done;
    end

    // Read multiplexer; the pop word is formed from the queue heads.
    always_comb begin
        reg_rdata = '0;
        case (sel)
            REG_STATUS: reg_rdata = status;
            REG_MODE:   reg_rdata = {{(WORD_W-2){1'b0}}, mode_in_blk_q, mode_out_blk_q};
            REG_POP:    reg_rdata = {8'h00, (in_level >= LW'(2)) ? ihead1 : 8'h00,
                                     8'h00, (in_level != '0)     ? ihead0 : 8'h00};
            default:    reg_rdata = '0;
        endcase
    end

    logic unused_ok;
    assign unused_ok = ^ohead1_unused;
endmodule

// File: rtl/tef_checker.sv
// Property checker for tef_packer, attached by bind. It watches register strokes,
// engine handshakes and the internal flags.
module tef_checker
    import tef_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [WORD_W-1:0]  reg_wdata,
    input logic               eng_out_valid,
    input logic               eng_out_ready,
    input logic [ENTRY_W-1:0] eng_out_entry,
    input logic               eng_in_ready,
    input logic [LW-1:0]      out_level,
    input logic [LW-1:0]      in_level,
    input logic               ovf,
    input logic               out_svc,
    input logic               out_done,
    input logic               mode_out_blk
);
    // A pair push into a queue without two free slots must flag overflow.
    assert_drop_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_PUSH_PAIR && out_level > LW'(DEPTH - 2)) |=> ovf);

    // An offered entry that is not taken stays offered and unchanged.
    assert_hold_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_out_valid && !eng_out_ready) |=> (eng_out_valid && $stable(eng_out_entry)));

    // Transmit done stays set until the count is reprogrammed.
    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && !(reg_wr && reg_addr == REG_OUT_CNT)) |=> out_done);

    // Without block mode the transmit service bit never appears.
    assert_no_svc_fifo_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_out_blk && !out_svc) |=> !out_svc);

    // Writing 1 to the overflow bit clears it.
    assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == REG_STATUS && reg_wdata[ST_OVF]) |=> !ovf);

    // Receive back-pressure only while bytes are held.
    assert_in_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_in_ready |-> (in_level != '0));
endmodule

bind tef_packer tef_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .eng_out_valid(eng_out_valid), .eng_out_ready(eng_out_ready),
    .eng_out_entry(eng_out_entry), .eng_in_ready(eng_in_ready),
    .out_level(out_level), .in_level(in_level),
    .ovf(ovf_q), .out_svc(out_svc_q), .out_done(out_done),
    .mode_out_blk(mode_out_blk_q)
);

// File: tb/sim_tef_packer.sv
module sim_tef_packer;
    import tef_pkg::*;
    localparam int DEPTH = 8;
    localparam int BLOCK = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_out_valid, eng_out_ready = 1'b0;
    logic [15:0] eng_out_entry;
    logic        eng_in_valid = 1'b0, eng_in_ready;
    logic [7:0]  eng_in_byte = '0;

    tef_packer #(.DEPTH(DEPTH), .BLOCK(BLOCK), .CNT_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_out_valid(eng_out_valid), .eng_out_ready(eng_out_ready),
        .eng_out_entry(eng_out_entry), .eng_in_valid(eng_in_valid),
        .eng_in_ready(eng_in_ready), .eng_in_byte(eng_in_byte)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] exp_out[$];
    logic [7:0]  exp_in[$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic check_status(input string req, input logic [31:0] exp);
        logic [31:0] s;
        rd_reg(REG_STATUS, s);
        check(req, s, exp);
    endtask

    // Driver: push a pair; the scoreboard expects the low half first (R1).
    task automatic push_pair(input logic [15:0] lo, input logic [15:0] hi);
        exp_out.push_back(lo);
        exp_out.push_back(hi);
        wr_reg(REG_PUSH_PAIR, {hi, lo});
    endtask

    // Driver: single entry; the junk upper half must never reach the engine (R2).
    task automatic push_one(input logic [15:0] v);
        exp_out.push_back(v);
        wr_reg(REG_PUSH_ONE, {16'hDEAD, v});
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        eng_in_valid = 1'b1; eng_in_byte = b;
        exp_in.push_back(b);
        @(posedge clk); #1;
        eng_in_valid = 1'b0;
    endtask

    // Pop read, expected word formed from the received-byte model (R4).
    task automatic pop_check();
        logic [31:0] d, e;
        e = '0;
        if (exp_in.size() >= 2) begin
            e[7:0] = exp_in.pop_front();
            e[23:16] = exp_in.pop_front();
        end else if (exp_in.size() == 1) begin
            e[7:0] = exp_in.pop_front();
        end
        rd_reg(REG_POP, d);
        check("R4 pop word", d, e);
    endtask

    // Monitor: compare each entry the engine takes against the scoreboard (R1, R2, R3).
    initial begin
        forever begin
            @(negedge clk); #2;
            if (rst_n && eng_out_valid && eng_out_ready) begin
                if (exp_out.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R3 unexpected entry actual=%h expected=none", eng_out_entry);
                end else begin
                    check("R1/R2 entry order", {16'h0, eng_out_entry}, {16'h0, exp_out.pop_front()});
                end
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R9 reset state
        check_status("R9 status after reset", 32'h0);
        check("R9 out valid", {31'h0, eng_out_valid}, 32'h0);
        check("R9 in ready", {31'h0, eng_in_ready}, 32'h1);

        // FIFO-mode transmit: pair, single, pair
        wr_reg(REG_OUT_CNT, 32'd5);
        push_pair(16'h0201, 16'h0302);
        push_one(16'h0104);
        push_pair(16'h0205, 16'h0306);
        check_status("R5 out not empty", 32'h010);
        @(negedge clk) eng_out_ready = 1'b1;
        repeat (10) @(posedge clk);
        check("R1 drained", exp_out.size(), 0);
        check_status("R6 out done, R7 no svc in fifo mode", 32'h400);

        // R3 overflow
        wr_reg(REG_OUT_CNT, 32'd0);
        @(negedge clk) eng_out_ready = 1'b0;
        for (int i = 0; i < 4; i++) push_pair(16'h0210 + 16'(i), 16'h0220 + 16'(i));
        check_status("R5 out full", 32'h050);
        wr_reg(REG_PUSH_PAIR, 32'h0BAD_0BAD);
        check_status("R3 pair dropped, ovf set", 32'h054);
        wr_reg(REG_PUSH_ONE, 32'h0000_0BAD);
        check_status("R3 single dropped", 32'h054);
        wr_reg(REG_STATUS, 32'h0);
        check_status("R8 zero write keeps flags", 32'h054);
        wr_reg(REG_STATUS, 32'h4);
        check_status("R8 ovf cleared", 32'h050);
        @(negedge clk) eng_out_ready = 1'b1;
        repeat (20) @(posedge clk);
        check("R3 queue contents intact", exp_out.size(), 0);
        check_status("R6 zero count never done", 32'h000);

        // R7 transmit block mode
        wr_reg(REG_MODE, 32'h1);
        wr_reg(REG_OUT_CNT, 32'd8);
        push_pair(16'h0231, 16'h0232);
        push_pair(16'h0233, 16'h0234);
        repeat (8) @(posedge clk);
        check_status("R7 out svc after one block", 32'h100);
        wr_reg(REG_STATUS, 32'h100);
        check_status("R8 out svc cleared", 32'h000);
        push_pair(16'h0235, 16'h0236);
        push_pair(16'h0237, 16'h0338);
        repeat (8) @(posedge clk);
        check_status("R7 svc again and R6 done", 32'h500);
        wr_reg(REG_STATUS, 32'h100);
        check_status("R8 clear keeps done", 32'h400);
        wr_reg(REG_OUT_CNT, 32'd8);
        check_status("R6 reprogram clears done", 32'h000);

        // R4 receive packing in FIFO mode
        wr_reg(REG_MODE, 32'h0);
        wr_reg(REG_IN_CNT, 32'd3);
        send_byte(8'hA1);
        send_byte(8'hB2);
        send_byte(8'hC3);
        check_status("R5 in not empty, R6 in done", 32'h820);
        pop_check();
        pop_check();
        pop_check();
        check_status("R4 receive queue empty", 32'h800);

        // R7 receive block mode, R5 full back-pressure
        wr_reg(REG_MODE, 32'h2);
        wr_reg(REG_IN_CNT, 32'd8);
        for (int i = 0; i < 4; i++) send_byte(8'h40 + 8'(i));
        check_status("R7 in svc after one block", 32'h220);
        wr_reg(REG_STATUS, 32'h200);
        check_status("R8 in svc cleared", 32'h020);
        for (int i = 0; i < 4; i++) send_byte(8'h50 + 8'(i));
        check("R5 in ready low when full", {31'h0, eng_in_ready}, 32'h0);
        check_status("R7 in svc again, R6 in done", 32'hA20);
        for (int i = 0; i < 4; i++) pop_check();
        check_status("R5 in empty", 32'hA00);
        wr_reg(REG_STATUS, 32'h304);
        check_status("R8 multi clear", 32'h800);

        summary();
        $finish;
    end
endmodule